// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block tracks in-flight instructions for two hardware threads that share one reorder buffer. Each thread asks for an entry in program order, tagging the request with its thread bit, and gets back a global entry index. Execution units later mark entries finished by index alone, in any order. The buffer hands finished entries back on a multi-slot retirement port, oldest first within each thread.

The storage is cut into two fixed halves, one per thread. Each half works as a circular queue with its own head, tail and occupancy count. A thread that fills its half is refused further entries. The other thread is not affected. When both threads have finished work at the head of their queues, retirement slots are shared by alternating between them. When only one thread is ready, that thread may use every slot.

A per-thread clear empties one half and leaves the other half as it was.

Top module: `smt_rob`

## Requirements
- R1: While reset is asserted, and straight after it, every retirement slot is invalid, both full flags are low, and the next index offered to either thread is local slot 0 of that thread's half.
- R2: An accepted allocation returns index {thread bit, local slot}, with the thread bit as the most significant bit. Successive allocations of one thread use local slots 0, 1, 2 and so on, wrapping modulo DEPTH/2.
- R3: A thread's full flag is high when DEPTH/2 of its entries are outstanding. An allocation request for a full thread is dropped and changes nothing. The other thread's allocations proceed normally.
- R4: Entries may be completed in any order through any completion port, by index only. Within a thread, retirement follows allocation order exactly and never skips an unfinished entry.
- R5: The completion mark is registered. An entry completed at a clock edge can appear on the retirement port from that edge onward, and never earlier. Entries shown on the retirement port are removed at the next edge.
- R6: When only one thread has finished entries at its head, up to RETIRE_W of them retire in the same cycle, with no slot left idle while that thread has more ready entries.
- R7: When both threads are ready, the slots alternate between the threads. The first slot goes to thread 0 in the first such cycle after reset, and to the opposite thread from the one that led in the previous such cycle.
- R8: Valid retirement slots are packed from slot 0 upward.
- R9: Asserting clear for a thread empties that thread's half and resets its pointers to slot 0. An allocation or completion for that thread in the same cycle is discarded. The other half is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Allocation request |
| allocTid | input | 1 | Thread of the allocation request |
| allocIdx | output | $clog2(DEPTH) | Global index that the request receives if it is accepted |
| allocFull | output | 2 | Per-thread partition-full flags (bit t = thread t) |
| cmplValid | input | CMPL_N | Per-port completion strobes |
| cmplIdx | input | CMPL_N*$clog2(DEPTH) | Completed entry index for each port, port c at bits c*IW upward |
| clear | input | 2 | Per-thread partition clear |
| retValid | output | RETIRE_W | Valid flag for each retirement slot |
| retIdx | output | RETIRE_W*$clog2(DEPTH) | Retired global index for each slot |

## Verification
The allocation index depends combinationally on the thread input and the tail pointer, so it is checked 1 ns after the inputs are driven, in the same cycle. A completion takes one edge to register: the bench's model marks an entry done only when it applies that edge, so the entry is first expected on the retirement port in the following cycle. Retirement outputs, full flags and the model state are compared at every falling edge against the state the model reached after the previous rising edge. Only then are the model's retirements, allocations, completions and clears applied for the next edge.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Strobes sent from the control to the done-bit datapath each cycle.
  typedef struct packed {
    logic       allocGo;   // an allocation is accepted this cycle
    logic       allocTid;  // thread that owns it
    logic [1:0] clrMask;   // per-thread partition clear
  } robStrobe_t;
endpackage

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CMPL_N = 2,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  robStrobe_t              strobe,
  input  logic [IDX_W-1:0]        allocIdx,
  input  logic [CMPL_N-1:0]       cmplValid,
  input  logic [CMPL_N*IDX_W-1:0] cmplIdx,
  output logic [DEPTH-1:0]        doneVec
);
  localparam int HALF = DEPTH / 2;

  logic [DEPTH-1:0] doneNext;
  logic [DEPTH-1:0] clrHit;

  // Map each entry to its owner's clear bit.
  for (genvar e = 0; e < DEPTH; e++) begin : g_clr
    assign clrHit[e] = strobe.clrMask[e >= HALF];
  end

  always_comb begin
    doneNext = doneVec;
    if (strobe.allocGo) doneNext[allocIdx] = 1'b0;
    for (int c = 0; c < CMPL_N; c++) begin
      if (cmplValid[c]) doneNext[cmplIdx[c*IDX_W +: IDX_W]] = 1'b1;
    end
    for (int e = 0; e < DEPTH; e++) begin
      if (clrHit[e]) doneNext[e] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneVec <= '0;
    else       doneVec <= doneNext;
  end

  // A completion on port 0 to a thread that is not being cleared must show up as done.
  p_cmpl_marks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid[0] && !strobe.clrMask[cmplIdx[IDX_W-1]])
      |=> doneVec[$past(cmplIdx[IDX_W-1:0])]);
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int RETIRE_W = 2,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocValid,
  input  logic                      allocTid,
  input  logic [1:0]                clear,
  input  logic [DEPTH-1:0]          doneVec,
  output robStrobe_t                strobe,
  output logic [IDX_W-1:0]          allocIdx,
  output logic [1:0]                allocFull,
  output logic [RETIRE_W-1:0]       retValid,
  output logic [RETIRE_W*IDX_W-1:0] retIdx
);
  localparam int HALF   = DEPTH / 2;
  localparam int LIDX_W = IDX_W - 1;
  localparam int CNT_W  = LIDX_W + 1;
  localparam int RDY_W  = $clog2(RETIRE_W + 1);

  logic [LIDX_W-1:0] head [2];
  logic [LIDX_W-1:0] tail [2];
  logic [CNT_W-1:0]  cnt  [2];
  logic              prio;

  logic [RDY_W-1:0]  rdy  [2];
  logic [RDY_W-1:0]  take [2];
  logic              allocGo;
  logic              bothRdy;
  logic              slotTid [RETIRE_W];

  assign allocFull[0] = (cnt[0] == CNT_W'(HALF));
  assign allocFull[1] = (cnt[1] == CNT_W'(HALF));
  assign allocGo      = allocValid && !allocFull[allocTid] && !clear[allocTid];
  assign allocIdx     = {allocTid, tail[allocTid]};
  assign strobe       = '{allocGo: allocGo, allocTid: allocTid, clrMask: clear};
  assign bothRdy      = (rdy[0] != '0) && (rdy[1] != '0);

  // Count the finished entries in an unbroken run from each head.
  always_comb begin
    logic              run;
    logic [LIDX_W-1:0] slot;
    for (int t = 0; t < 2; t++) begin
      rdy[t] = '0;
      run    = 1'b1;
      for (int k = 0; k < RETIRE_W; k++) begin
        slot = head[t] + LIDX_W'(k);
        if (run && (k < int'(cnt[t])) && doneVec[{t[0], slot}]) rdy[t] = rdy[t] + RDY_W'(1);
        else run = 1'b0;
      end
    end
  end

  // Fill the slots, alternating threads while both still have ready entries.
  always_comb begin
    logic cur;
    logic pick;
    logic hit;
    cur     = prio;
    take[0] = '0;
    take[1] = '0;
    retValid = '0;
    retIdx   = '0;
    for (int s = 0; s < RETIRE_W; s++) begin
      hit  = 1'b0;
      pick = cur;
      if (take[cur] < rdy[cur]) begin
        hit = 1'b1;
      end else if (take[!cur] < rdy[!cur]) begin
        hit  = 1'b1;
        pick = !cur;
      end
      slotTid[s] = pick;
      if (hit) begin
        retValid[s] = 1'b1;
        retIdx[s*IDX_W +: IDX_W] = {pick, head[pick] + LIDX_W'(take[pick])};
        take[pick] = take[pick] + RDY_W'(1);
        cur = !pick;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prio <= 1'b0;
      for (int t = 0; t < 2; t++) begin
        head[t] <= '0;
        tail[t] <= '0;
        cnt[t]  <= '0;
      end
    end else begin
      if (bothRdy) prio <= !prio;
      for (int t = 0; t < 2; t++) begin
        if (clear[t]) begin
          head[t] <= '0;
          tail[t] <= '0;
          cnt[t]  <= '0;
        end else begin
          head[t] <= head[t] + LIDX_W'(take[t]);
          tail[t] <= tail[t] + LIDX_W'(allocGo && (allocTid == t[0]));
          cnt[t]  <= cnt[t] + CNT_W'(allocGo && (allocTid == t[0])) - CNT_W'(take[t]);
        end
      end
    end
  end

  // Assertions guarding the control.
  for (genvar t = 0; t < 2; t++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
      cnt[t] <= CNT_W'(HALF));
    p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
      (allocValid && (allocTid == t[0]) && allocFull[t] && !clear[t]) |=> $stable(tail[t]));
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
      clear[t] |=> (cnt[t] == '0) && (head[t] == '0) && (tail[t] == '0));
  end

  p_slots_packed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retValid & (retValid + RETIRE_W'(1))) == '0);

  if (RETIRE_W >= 2) begin : g_alt
    p_alternate_r7: assert property (@(posedge clk) disable iff (!rstN)
      bothRdy |-> (retValid[1:0] == 2'b11) && (slotTid[0] != slotTid[1]));
  end
endmodule

// File: rtl/smt_rob.sv
module smt_rob
  import rob_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int RETIRE_W = 2,
  parameter int CMPL_N   = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                allocValid,
  input  logic                                allocTid,
  output logic [$clog2(DEPTH)-1:0]            allocIdx,
  output logic [1:0]                          allocFull,
  input  logic [CMPL_N-1:0]                   cmplValid,
  input  logic [CMPL_N*$clog2(DEPTH)-1:0]     cmplIdx,
  input  logic [1:0]                          clear,
  output logic [RETIRE_W-1:0]                 retValid,
  output logic [RETIRE_W*$clog2(DEPTH)-1:0]   retIdx
);
  localparam int IDX_W = $clog2(DEPTH);

  robStrobe_t       strobe;
  logic [DEPTH-1:0] doneVec;

  initial begin
    assert ((DEPTH >= 4) && ((DEPTH & (DEPTH - 1)) == 0))
      else $error("DEPTH must be a power of two, at least 4");
  end

  rob_ctrl #(.DEPTH(DEPTH), .RETIRE_W(RETIRE_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTid(allocTid),
    .clear(clear), .doneVec(doneVec), .strobe(strobe), .allocIdx(allocIdx),
    .allocFull(allocFull), .retValid(retValid), .retIdx(retIdx)
  );

  rob_data #(.DEPTH(DEPTH), .CMPL_N(CMPL_N), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx), .doneVec(doneVec)
  );
endmodule

// File: tb/smt_rob_bench.sv
module smt_rob_bench;
  localparam int DEPTH = 16;
  localparam int W     = 2;
  localparam int CN    = 2;
  localparam int IW    = 4;
  localparam int HALF  = DEPTH / 2;
  localparam int CYCLES = 2000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          allocValid = 1'b0;
  logic          allocTid = 1'b0;
  logic [IW-1:0] allocIdx;
  logic [1:0]    allocFull;
  logic [CN-1:0] cmplValid = '0;
  logic [CN*IW-1:0] cmplIdx = '0;
  logic [1:0]    clear = '0;
  logic [W-1:0]  retValid;
  logic [W*IW-1:0] retIdx;

  always #5 clk = ~clk;

  smt_rob #(.DEPTH(DEPTH), .RETIRE_W(W), .CMPL_N(CN)) u_smt_rob (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTid(allocTid),
    .allocIdx(allocIdx), .allocFull(allocFull), .cmplValid(cmplValid),
    .cmplIdx(cmplIdx), .clear(clear), .retValid(retValid), .retIdx(retIdx)
  );

  // Behavioural model: one queue of global indices per thread.
  int q0[$];
  int q1[$];
  bit [DEPTH-1:0] doneM;
  int tailM[2];
  bit prioM;
  bit clrSince[2];
  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  function automatic int qsz(int t);
    return (t == 0) ? q0.size() : q1.size();
  endfunction
  function automatic int qat(int t, int k);
    return (t == 0) ? q0[k] : q1[k];
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (CYCLES + 1000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    doneM = '0; tailM[0] = 0; tailM[1] = 0; prioM = 0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(retValid == '0, "R1", "retValid in reset", int'(retValid), 0);
    check(allocFull == 2'b00, "R1", "allocFull in reset", int'(allocFull), 0);
    allocTid = 1'b1; #1;
    check(allocIdx == IW'(HALF), "R1", "allocIdx thread1 in reset", int'(allocIdx), HALF);
    allocTid = 1'b0;
    @(negedge clk); rstN = 1'b1;

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      int rdy[2];
      int take[2];
      int expI[W];
      bit [W-1:0] expV;
      bit cur;
      int pick;
      string tag;
      int pend[$];
      bit aV, aT;
      bit [CN-1:0] cV;
      int cI[CN];
      bit [1:0] clr;
      bit aGo;
      @(negedge clk);

      // Expected retirement from the model state reached after the last edge.
      for (int t = 0; t < 2; t++) begin
        rdy[t] = 0;
        for (int k = 0; k < W; k++)
          if (k < qsz(t) && rdy[t] == k && doneM[qat(t, k)]) rdy[t]++;
      end
      cur = prioM; take[0] = 0; take[1] = 0; expV = '0;
      for (int s = 0; s < W; s++) begin
        expI[s] = 0;
        pick = -1;
        if (take[cur] < rdy[cur]) pick = int'(cur);
        else if (take[!cur] < rdy[!cur]) pick = int'(!cur);
        if (pick >= 0) begin
          expV[s] = 1'b1;
          expI[s] = qat(pick, take[pick]);
          take[pick]++;
          cur = (pick == 0);
        end
      end
      tag = (rdy[0] > 0 && rdy[1] > 0) ? "R7" : "R6";
      check(retValid == expV, {"R4 R8 ", tag}, "retValid", int'(retValid), int'(expV));
      for (int s = 0; s < W; s++)
        if (expV[s])
          check(retIdx[s*IW +: IW] == IW'(expI[s]), {"R4 R5 ", tag}, "retIdx",
                int'(retIdx[s*IW +: IW]), expI[s]);
      check(allocFull == {q1.size() == HALF, q0.size() == HALF}, "R3", "allocFull",
            int'(allocFull), int'({q1.size() == HALF, q0.size() == HALF}));

      // Stimulus by phase.
      aT = (cyc < 300) ? 1'b0 : 1'($urandom_range(1));
      aV = (cyc >= 1500 && cyc < 1700) ? 1'b1 : ($urandom_range(99) < 60);
      clr = '0;
      if (cyc >= 300 && !(cyc >= 1450 && cyc < 1700)) begin
        clr[0] = ($urandom_range(199) == 0);
        clr[1] = ($urandom_range(199) == 0);
      end
      foreach (q0[i]) if (!doneM[q0[i]]) pend.push_back(q0[i]);
      foreach (q1[i]) if (!doneM[q1[i]]) pend.push_back(q1[i]);
      cV = '0;
      for (int c = 0; c < CN; c++) begin
        cI[c] = 0;
        if (!(cyc >= 1500 && cyc < 1700) && pend.size() > 0 && $urandom_range(99) < 70) begin
          int j;
          j = $urandom_range(pend.size() - 1);
          cI[c] = pend[j];
          pend.delete(j);
          cV[c] = 1'b1;
        end
      end
      allocValid = aV; allocTid = aT; clear = clr; cmplValid = cV;
      for (int c = 0; c < CN; c++) cmplIdx[c*IW +: IW] = IW'(cI[c]);
      #1;
      aGo = aV && (qsz(int'(aT)) < HALF) && !clr[aT];
      if (aGo)
        check(allocIdx == IW'(int'(aT) * HALF + tailM[aT]), clrSince[aT] ? "R9" : "R2",
              "allocIdx", int'(allocIdx), int'(aT) * HALF + tailM[aT]);

      // Apply the edge to the model: retire, allocate, complete, clear.
      for (int k = 0; k < take[0]; k++) void'(q0.pop_front());
      for (int k = 0; k < take[1]; k++) void'(q1.pop_front());
      if (rdy[0] > 0 && rdy[1] > 0) prioM = !prioM;
      if (aGo) begin
        int gi;
        gi = int'(aT) * HALF + tailM[aT];
        if (aT) q1.push_back(gi); else q0.push_back(gi);
        doneM[gi] = 1'b0;
        tailM[aT] = (tailM[aT] + 1) % HALF;
        clrSince[aT] = 1'b0;
      end
      for (int c = 0; c < CN; c++) if (cV[c]) doneM[cI[c]] = 1'b1;
      for (int t = 0; t < 2; t++) if (clr[t]) begin
        if (t == 0) q0.delete(); else q1.delete();
        tailM[t] = 0;
        clrSince[t] = 1'b1;
        for (int e = t * HALF; e < (t + 1) * HALF; e++) doneM[e] = 1'b0;
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule